// File: doc/BRIEF.md
# Selection Sequence Step Tracker

This block supervises an initiator's selection sequence on a parallel SCSI bus from the point where arbitration has been won and the target has answered selection. It watches the three phase lines that the target drives (MSG, C/D, I/O), together with a request strobe and a byte-acknowledge strobe from a separate byte handshake engine. It walks through the expected message-out bytes and then the command bytes. It drives the attention (ATN) line towards the target and reports in a 3-bit step code how far the sequence got before it finished or was cut short.

Four selection variants are supported: plain selection (no attention), selection with one message byte under attention, selection with up to three message bytes under attention, and a stop-after-message variant that halts with attention still raised after the single message byte. The command length is an input latched at start. When the sequence ends, a one-cycle done pulse marks the moment. The step code and an early-termination flag stay readable until the next start.

Top module: `sel_step_tracker`

## Requirements
- R1: After reset the block is idle: `busy_o`, `atn_o`, `done_o` and `early_o` are 0 and `step_o` is 0.
- R2: Phases are coded on `phase_i` = {MSG, C/D, I/O}: data out 000, data in 001, command 010, status 011, message out 110, message in 111. The block sees a byte request only when `req_i` is high. A request whose phase differs from the one expected (message out during the message stage, command during the command stage) ends the sequence.
- R3: `variant_i` codes are 0 = plain, 1 = one message byte with attention, 2 = up to three message bytes with attention, 3 = stop after one message byte. A start while idle raises `busy_o` on the next cycle and sets `atn_o` high for variants 1 to 3 and low for variant 0.
- R4: For variants 1 and 2, `atn_o` falls in the cycle after the request of the last message byte (the first byte for variant 1, the third byte for variant 2) is accepted, so it is already low during that byte's acknowledge. It stays high during the acknowledge of earlier message bytes.
- R5: If the first request under variants 1 to 3 does not show message out, the sequence ends with step 0, `early_o` = 1 and `atn_o` still high.
- R6: Under variant 3 the acknowledge of the message byte ends the sequence with step 1, `early_o` = 0 and `atn_o` still high.
- R7: Step 2 ends the sequence in three cases. Under variant 0 the first request is not command phase. Under variant 1 the request after the message byte is not command phase, with `atn_o` low. Under variant 2 a request that is not message out comes after one or two message bytes (with `atn_o` high), or a request that is not command phase comes after three message bytes. In each case `early_o` = 1.
- R8: A non-command request after at least one command byte has been acknowledged ends the sequence with step 3 and `early_o` = 1.
- R9: The acknowledge of the last command byte ends the sequence with step 4 and `early_o` = 0, and `atn_o` is low.
- R10: The command byte count is `cmd_len_i` clamped to the range 6 to 12 and latched at start.
- R11: `done_o` is a single-cycle pulse in the cycle after the ending event. `step_o` and `early_o` hold their values from that pulse until the next accepted start.
- R12: A start while busy is ignored: variant, length and `atn_o` are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a sequence (accepted only when idle) |
| variant_i | input | 2 | Selection variant code |
| cmd_len_i | input | CNT_W | Requested command byte count |
| phase_i | input | 3 | Target phase {MSG, C/D, I/O} |
| req_i | input | 1 | Target requests a byte; phase_i valid |
| ack_i | input | 1 | Byte handshake for the accepted request finished |
| atn_o | output | 1 | Attention towards the target |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| early_o | output | 1 | Sequence ended on an unexpected phase |
| step_o | output | 3 | Step code reached |

## Verification
The bench aims at the step boundaries where an off-by-one moves the code. These are a phase change after exactly one or two of three message bytes (a design that counts wrongly reports step 0 or completes), and a phase change after the first command byte (a design that reports step 2 misses that command bytes moved). It probes ATN during each message acknowledge: a design that drops ATN after the handshake, or too early in the three-byte variant, shows the wrong level there. It also drives command lengths outside 6..12, where a design without the clamp ends too early or too late. Finally, it pulses a second start mid-sequence, which a design without the idle guard would accept, changing ATN or the length.

// File: rtl/sel_step_pkg.sv
package sel_step_pkg;

  typedef enum logic [1:0] {
    VAR_PLAIN = 2'd0,
    VAR_ATN1  = 2'd1,
    VAR_ATN3  = 2'd2,
    VAR_STOP  = 2'd3
  } sel_var_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MSG_WAIT,
    ST_MSG_XFER,
    ST_CMD_WAIT,
    ST_CMD_XFER
  } sel_state_e;

  // phase coding {MSG, C/D, I/O}
  localparam logic [2:0] PH_MSG_OUT = 3'b110;
  localparam logic [2:0] PH_COMMAND = 3'b010;

  localparam logic [2:0] STEP_NO_MSGOUT = 3'd0;
  localparam logic [2:0] STEP_STOPPED   = 3'd1;
  localparam logic [2:0] STEP_NO_CMD    = 3'd2;
  localparam logic [2:0] STEP_CMD_SHORT = 3'd3;
  localparam logic [2:0] STEP_COMPLETE  = 3'd4;

endpackage

// File: rtl/sel_len_clamp.sv
module sel_len_clamp #(
  parameter int W     = 4,
  parameter int LO    = 6,
  parameter int HI    = 12
) (
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] len_o
);
  localparam logic [W-1:0] LoV = W'(LO);
  localparam logic [W-1:0] HiV = W'(HI);

  always_comb begin
    if (raw_i < LoV)      len_o = LoV;
    else if (raw_i > HiV) len_o = HiV;
    else                  len_o = raw_i;
  end
endmodule

// File: rtl/sel_byte_ctr.sv
module sel_byte_ctr #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] count_o
);
  logic [W-1:0] cnt_d, cnt_q;
  logic         cnt_en;

  assign cnt_en = clr_i | inc_i;

  always_comb begin
    if (clr_i) cnt_d = '0;
    else       cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/sel_phase_decode.sv
module sel_phase_decode
  import sel_step_pkg::*;
(
  input  logic [2:0] phase_i,
  output logic       is_msg_out_o,
  output logic       is_command_o
);
  assign is_msg_out_o = (phase_i == PH_MSG_OUT);
  assign is_command_o = (phase_i == PH_COMMAND);
endmodule

// File: rtl/sel_step_tracker.sv
module sel_step_tracker
  import sel_step_pkg::*;
#(
  parameter int CNT_W   = 4,
  parameter int CMD_MIN = 6,
  parameter int CMD_MAX = 12,
  parameter int MSG_MAX = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [1:0]       variant_i,
  input  logic [CNT_W-1:0] cmd_len_i,
  input  logic [2:0]       phase_i,
  input  logic             req_i,
  input  logic             ack_i,
  output logic             atn_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             early_o,
  output logic [2:0]       step_o
);
  localparam int MSG_W = $clog2(MSG_MAX + 1);

  sel_state_e       state_q, state_d;
  sel_var_e         var_q, var_d, var_in;
  logic [CNT_W-1:0] len_q, len_d, len_clamped;
  logic [2:0]       step_q, step_d;
  logic             atn_q, atn_d, done_q, done_d, early_q, early_d;
  logic             cnt_clr, msg_inc, cmd_inc;
  logic [MSG_W-1:0] msg_cnt, msg_last;
  logic [CNT_W-1:0] cmd_cnt;
  logic             is_msg_out, is_command, last_msg, last_cmd;

  assign var_in = sel_var_e'(variant_i);

  sel_len_clamp #(.W(CNT_W), .LO(CMD_MIN), .HI(CMD_MAX)) u_clamp (
    .raw_i (cmd_len_i),
    .len_o (len_clamped)
  );

  sel_phase_decode u_phase (
    .phase_i      (phase_i),
    .is_msg_out_o (is_msg_out),
    .is_command_o (is_command)
  );

  sel_byte_ctr #(.W(MSG_W)) u_msg_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (cnt_clr),
    .inc_i   (msg_inc),
    .count_o (msg_cnt)
  );

  sel_byte_ctr #(.W(CNT_W)) u_cmd_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (cnt_clr),
    .inc_i   (cmd_inc),
    .count_o (cmd_cnt)
  );

  // index of the final message byte for the latched variant
  always_comb begin
    if (var_q == VAR_ATN3) msg_last = MSG_W'(MSG_MAX - 1);
    else                   msg_last = '0;
  end

  assign last_msg = (msg_cnt == msg_last);
  assign last_cmd = (cmd_cnt == len_q - CNT_W'(1));

  always_comb begin
    state_d = state_q;
    var_d   = var_q;
    len_d   = len_q;
    step_d  = step_q;
    atn_d   = atn_q;
    early_d = early_q;
    done_d  = 1'b0;
    cnt_clr = 1'b0;
    msg_inc = 1'b0;
    cmd_inc = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          var_d   = var_in;
          len_d   = len_clamped;
          cnt_clr = 1'b1;
          step_d  = STEP_NO_MSGOUT;
          early_d = 1'b0;
          atn_d   = (var_in != VAR_PLAIN);
          state_d = (var_in == VAR_PLAIN) ? ST_CMD_WAIT : ST_MSG_WAIT;
        end
      end
      ST_MSG_WAIT: begin
        if (req_i) begin
          if (is_msg_out) begin
            state_d = ST_MSG_XFER;
            if (last_msg && var_q != VAR_STOP) atn_d = 1'b0;
          end else begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
            early_d = 1'b1;
            step_d  = (msg_cnt == '0) ? STEP_NO_MSGOUT : STEP_NO_CMD;
          end
        end
      end
      ST_MSG_XFER: begin
        if (ack_i) begin
          msg_inc = 1'b1;
          if (!last_msg) begin
            state_d = ST_MSG_WAIT;
          end else if (var_q == VAR_STOP) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
            step_d  = STEP_STOPPED;
          end else begin
            state_d = ST_CMD_WAIT;
          end
        end
      end
      ST_CMD_WAIT: begin
        if (req_i) begin
          if (is_command) begin
            state_d = ST_CMD_XFER;
          end else begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
            early_d = 1'b1;
            step_d  = (cmd_cnt == '0) ? STEP_NO_CMD : STEP_CMD_SHORT;
          end
        end
      end
      ST_CMD_XFER: begin
        if (ack_i) begin
          cmd_inc = 1'b1;
          if (last_cmd) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
            step_d  = STEP_COMPLETE;
          end else begin
            state_d = ST_CMD_WAIT;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      var_q   <= VAR_PLAIN;
      len_q   <= CNT_W'(CMD_MIN);
      step_q  <= '0;
      atn_q   <= 1'b0;
      early_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      var_q   <= var_d;
      len_q   <= len_d;
      step_q  <= step_d;
      atn_q   <= atn_d;
      early_q <= early_d;
      done_q  <= done_d;
    end
  end

  assign atn_o   = atn_q;
  assign busy_o  = (state_q != ST_IDLE);
  assign done_o  = done_q;
  assign early_o = early_q;
  assign step_o  = step_q;

  p_plain_no_atn_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i && variant_i == 2'd0) |=> !atn_o);

  p_cmd_stage_atn_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CMD_WAIT || state_q == ST_CMD_XFER) |-> !atn_o);

  p_stop_keeps_atn_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && step_o == STEP_STOPPED) |-> atn_o);

  p_step_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (step_o <= STEP_COMPLETE));

  p_cmd_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (cmd_cnt < len_q && len_q >= CNT_W'(CMD_MIN) && len_q <= CNT_W'(CMD_MAX)));

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_step_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> ($stable(step_o) && $stable(early_o)));

  p_busy_start_ignored_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && state_q != ST_MSG_WAIT && state_q != ST_MSG_XFER) |=> $stable(var_q));

endmodule

// File: tb/sel_step_tracker_bench.sv
module sel_step_tracker_bench;
  localparam logic [2:0] P_DOUT = 3'b000;
  localparam logic [2:0] P_DIN  = 3'b001;
  localparam logic [2:0] P_CMD  = 3'b010;
  localparam logic [2:0] P_STAT = 3'b011;
  localparam logic [2:0] P_MOUT = 3'b110;
  localparam logic [2:0] P_MIN  = 3'b111;

  logic       clk, rst_n, start_i, req_i, ack_i;
  logic [1:0] variant_i;
  logic [3:0] cmd_len_i;
  logic [2:0] phase_i;
  logic       atn_o, busy_o, done_o, early_o;
  logic [2:0] step_o;

  int checks = 0;
  int fails  = 0;
  logic atn_mid, got_done, got_early, got_atn, any_done;
  logic [2:0] got_step;

  sel_step_tracker u_sel_step_tracker (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .variant_i(variant_i),
    .cmd_len_i(cmd_len_i), .phase_i(phase_i), .req_i(req_i), .ack_i(ack_i),
    .atn_o(atn_o), .busy_o(busy_o), .done_o(done_o), .early_o(early_o),
    .step_o(step_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_start(input logic [1:0] v, input logic [3:0] len);
    @(negedge clk);
    start_i = 1'b1; variant_i = v; cmd_len_i = len;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic send_byte(input logic [2:0] p);
    @(negedge clk);
    req_i = 1'b1; phase_i = p;
    @(negedge clk);
    req_i = 1'b0; ack_i = 1'b1; atn_mid = atn_o;
    @(negedge clk);
    ack_i = 1'b0;
    got_done = done_o; got_step = step_o; got_early = early_o; got_atn = atn_o;
  endtask

  task automatic send_bad(input logic [2:0] p);
    @(negedge clk);
    req_i = 1'b1; phase_i = p;
    @(negedge clk);
    req_i = 1'b0;
    got_done = done_o; got_step = step_o; got_early = early_o; got_atn = atn_o;
  endtask

  task automatic run_cmds(input int n);
    any_done = 1'b0;
    for (int i = 0; i < n; i++) begin
      send_byte(P_CMD);
      if (i < n - 1 && got_done) any_done = 1'b1;
    end
  endtask

  task automatic t_reset;
    check("R1 busy", busy_o, 0);
    check("R1 atn", atn_o, 0);
    check("R1 done", done_o, 0);
    check("R1 early", early_o, 0);
    check("R1 step", step_o, 0);
  endtask

  task automatic t_plain_full;
    do_start(2'd0, 4'd6);
    check("R3 busy after start", busy_o, 1);
    check("R3 plain atn low", atn_o, 0);
    run_cmds(6);
    check("R9 no premature done", any_done, 0);
    check("R9 done", got_done, 1);
    check("R9 step complete", got_step, 4);
    check("R9 early clear", got_early, 0);
    @(negedge clk);
    check("R11 done one cycle", done_o, 0);
    check("R11 step held", step_o, 4);
    check("R11 busy low", busy_o, 0);
  endtask

  task automatic t_atn1_full;
    do_start(2'd1, 4'd10);
    check("R3 atn1 atn high", atn_o, 1);
    send_byte(P_MOUT);
    check("R4 atn low during last msg ack", atn_mid, 0);
    run_cmds(10);
    check("R9 atn1 step", got_step, 4);
    check("R9 atn1 done", got_done, 1);
    check("R9 atn low at end", got_atn, 0);
  endtask

  task automatic t_atn3_full;
    do_start(2'd2, 4'd12);
    check("R3 atn3 atn high", atn_o, 1);
    send_byte(P_MOUT);
    check("R4 atn high byte1 ack", atn_mid, 1);
    send_byte(P_MOUT);
    check("R4 atn high byte2 ack", atn_mid, 1);
    send_byte(P_MOUT);
    check("R4 atn low byte3 ack", atn_mid, 0);
    run_cmds(12);
    check("R9 atn3 no premature done", any_done, 0);
    check("R9 atn3 step", got_step, 4);
  endtask

  task automatic t_step0;
    do_start(2'd1, 4'd6);
    send_bad(P_DIN);
    check("R5 done", got_done, 1);
    check("R5 step 0", got_step, 0);
    check("R5 early", got_early, 1);
    check("R5 atn kept", got_atn, 1);
  endtask

  task automatic t_step1;
    do_start(2'd3, 4'd6);
    send_byte(P_MOUT);
    check("R6 atn during ack", atn_mid, 1);
    check("R6 done", got_done, 1);
    check("R6 step 1", got_step, 1);
    check("R6 early clear", got_early, 0);
    check("R6 atn kept", got_atn, 1);
  endtask

  task automatic t_step2;
    do_start(2'd1, 4'd6);
    send_byte(P_MOUT);
    send_bad(P_STAT);
    check("R7 atn1 step 2", got_step, 2);
    check("R7 atn1 early", got_early, 1);
    check("R7 atn1 atn low", got_atn, 0);
    do_start(2'd0, 4'd6);
    send_bad(P_MIN);
    check("R7 plain step 2", got_step, 2);
    check("R2 message in unexpected", got_done, 1);
    do_start(2'd2, 4'd6);
    send_byte(P_MOUT);
    send_byte(P_MOUT);
    send_bad(P_CMD);
    check("R7 atn3 two bytes step 2", got_step, 2);
    check("R7 atn3 two bytes atn high", got_atn, 1);
    do_start(2'd2, 4'd6);
    send_byte(P_MOUT);
    send_bad(P_DOUT);
    check("R7 atn3 one byte step 2", got_step, 2);
    do_start(2'd2, 4'd6);
    send_byte(P_MOUT);
    send_byte(P_MOUT);
    send_byte(P_MOUT);
    send_bad(P_DIN);
    check("R7 atn3 three bytes step 2", got_step, 2);
    check("R7 atn3 three bytes atn low", got_atn, 0);
  endtask

  task automatic t_step3;
    do_start(2'd0, 4'd8);
    run_cmds(1);
    send_bad(P_DOUT);
    check("R8 after one cmd step 3", got_step, 3);
    do_start(2'd0, 4'd8);
    run_cmds(3);
    send_bad(P_MOUT);
    check("R8 step 3", got_step, 3);
    check("R8 early", got_early, 1);
    @(negedge clk);
    check("R11 early held", early_o, 1);
    check("R11 step 3 held", step_o, 3);
  endtask

  task automatic t_clamp;
    do_start(2'd0, 4'd2);
    run_cmds(5);
    check("R10 low clamp not done at 5", got_done, 0);
    send_byte(P_CMD);
    check("R10 low clamp done at 6", got_done, 1);
    check("R10 low clamp step", got_step, 4);
    do_start(2'd0, 4'd15);
    run_cmds(11);
    check("R10 high clamp not done at 11", got_done, 0);
    send_byte(P_CMD);
    check("R10 high clamp done at 12", got_done, 1);
  endtask

  task automatic t_busy_start;
    do_start(2'd1, 4'd6);
    @(negedge clk);
    start_i = 1'b1; variant_i = 2'd0; cmd_len_i = 4'd12;
    @(negedge clk);
    start_i = 1'b0;
    check("R12 atn unchanged", atn_o, 1);
    check("R12 busy", busy_o, 1);
    send_byte(P_MOUT);
    check("R12 variant kept atn drop", atn_mid, 0);
    run_cmds(6);
    check("R12 length kept", got_done, 1);
    check("R12 step", got_step, 4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; req_i = 1'b0; ack_i = 1'b0;
    variant_i = 2'd0; cmd_len_i = 4'd6; phase_i = 3'b000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_plain_full();
    t_atn1_full();
    t_atn3_full();
    t_step0();
    t_step1();
    t_step2();
    t_step3();
    t_clamp();
    t_busy_start();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule